// File: doc/BRIEF.md
# Pixel Region Event Packer

This block is the common write path shared by a rectangular group of pixel cells. When a particle crosses the group, one or more pixels report a rising discriminator edge. The block marks the arrival time of the event by capturing the value of a free-running bunch counter. It records which pixels took part. It then waits for every participating pixel to finish its time-over-threshold count. At that point it emits one packet carrying the arrival time, a hit map and a 4-bit count for every pixel, and pulses a write strobe toward the region buffer. In the same cycle it pulses an acknowledge back to the pixels.

While an event is open, the OR of the accepted rising edges goes back to the pixels, so that idle cells can go blind. Because all pixels share one arrival time and one write, the region stays busy until the slowest pixel of the event is done. Region rows, columns and counter width are parameters; 2x2 and 4x4 are the configurations of interest.

Top module: `prw_write_logic`

## Requirements
- R1: After reset, `wr_en` and `ack` are low and `pkt_toa`, `pkt_hitmap` and `pkt_tot` are all zero.
- R2: `redge_or` is high in the same cycle, combinationally, whenever at least one pixel shows a rising edge while its idle flag is high.
- R3: The first accepted edge when no event is open captures the `bx_count` value of that cycle as the event arrival time. Edges accepted later in the same event leave it unchanged.
- R4: Bit i of `pkt_hitmap` is set exactly when pixel i had an accepted rising edge between the opening cycle and the cycle before the write.
- R5: `wr_en` and `ack` rise together in the cycle after the first cycle in which every hit pixel shows ready. Each is a single-cycle pulse.
- R6: In the write packet, ToT field i (bits 4i+3 down to 4i of `pkt_tot`) equals pixel i's `pix_tot` field as sampled in the cycle before the write, for every hit pixel.
- R7: ToT fields of pixels not in the hit map are zero in the packet.
- R8: Ready flags of pixels outside the hit map do not trigger or block the write.
- R9: A rising edge in the cycle in which `ack` is high opens a new event and captures a new arrival time.
- R10: A rising edge arriving in the cycle in which the write condition is met is dropped. It neither enters the packet nor opens an event.
- R11: Between writes, `pkt_toa`, `pkt_hitmap` and `pkt_tot` hold their last values.
- R12: A rising edge from a pixel whose idle flag is low is ignored. It does not raise `redge_or`, set a hit-map bit or open an event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_redge | input | ROWS*COLS | Per-pixel synchronized rising-edge flag |
| pix_idle | input | ROWS*COLS | Per-pixel idle flag |
| pix_ready | input | ROWS*COLS | Per-pixel count-finished flag |
| pix_tot | input | 4*ROWS*COLS | Per-pixel 4-bit ToT values, pixel i in bits 4i+3:4i |
| bx_count | input | CNT_W | External bunch counter |
| redge_or | output | 1 | OR of accepted rising edges, fed back to pixels |
| wr_en | output | 1 | Single-cycle buffer write strobe |
| ack | output | 1 | Single-cycle acknowledge to all pixels |
| pkt_toa | output | CNT_W | Packet arrival time |
| pkt_hitmap | output | ROWS*COLS | Packet hit map |
| pkt_tot | output | 4*ROWS*COLS | Packet ToT fields |

## Verification
A stuck or wrongly cleared open-event flag shows at the ports within a single event. The write then either never follows the last ready flag, or appears without any edge. A hit map that keeps stale bits from the previous event shows in the very next packet, as extra set bits and non-zero ToT fields for pixels that were never hit. An arrival-time register that reloads during an open event shows as the wrong `pkt_toa` on the first event that has staggered edges. Sweeping every hit pattern of a 2x2 region, with non-hit pixels held ready, exposes each of these within one or two events.

// File: rtl/prw_pkg.sv
package prw_pkg;
    localparam int TOT_W = 4;

    typedef enum logic {
        EV_IDLE = 1'b0,
        EV_OPEN = 1'b1
    } ev_state_e;

    function automatic logic none_pending(input logic [63:0] map, input logic [63:0] rdy);
        return ((map & ~rdy) == 64'd0);
    endfunction
endpackage

// File: rtl/prw_edge_qual.sv
module prw_edge_qual #(
    parameter int NPIX = 4
) (
    input  logic [NPIX-1:0] redge,
    input  logic [NPIX-1:0] idle,
    output logic [NPIX-1:0] accepted,
    output logic            any_edge
);
    assign accepted = redge & idle;
    assign any_edge = |accepted;
endmodule

// File: rtl/prw_toa_reg.sv
module prw_toa_reg #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] toa
);
    always_ff @(posedge clk) begin
        if (rst)       toa <= '0;
        else if (load) toa <= count;
    end
endmodule

// File: rtl/prw_hitmap.sv
module prw_hitmap #(
    parameter int NPIX = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clear,
    input  logic [NPIX-1:0] set_bits,
    output logic [NPIX-1:0] map
);
    always_ff @(posedge clk) begin
        if (rst || clear) map <= '0;
        else              map <= map | set_bits;
    end
endmodule

// File: rtl/prw_packer.sv
module prw_packer
    import prw_pkg::*;
#(
    parameter int NPIX  = 4,
    parameter int CNT_W = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  fire,
    input  logic [CNT_W-1:0]      toa,
    input  logic [NPIX-1:0]       map,
    input  logic [NPIX*TOT_W-1:0] tot,
    output logic [CNT_W-1:0]      pkt_toa,
    output logic [NPIX-1:0]       pkt_hitmap,
    output logic [NPIX*TOT_W-1:0] pkt_tot
);
    logic [NPIX*TOT_W-1:0] tot_masked;

    for (genvar g = 0; g < NPIX; g++) begin : g_mask
        assign tot_masked[g*TOT_W +: TOT_W] = map[g] ? tot[g*TOT_W +: TOT_W] : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pkt_toa    <= '0;
            pkt_hitmap <= '0;
            pkt_tot    <= '0;
        end else if (fire) begin
            pkt_toa    <= toa;
            pkt_hitmap <= map;
            pkt_tot    <= tot_masked;
        end
    end
endmodule

// File: rtl/prw_write_logic.sv
module prw_write_logic
    import prw_pkg::*;
#(
    parameter int ROWS  = 2,
    parameter int COLS  = 2,
    parameter int CNT_W = 8,
    localparam int NPIX = ROWS * COLS
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NPIX-1:0]       pix_redge,
    input  logic [NPIX-1:0]       pix_idle,
    input  logic [NPIX-1:0]       pix_ready,
    input  logic [NPIX*TOT_W-1:0] pix_tot,
    input  logic [CNT_W-1:0]      bx_count,
    output logic                  redge_or,
    output logic                  wr_en,
    output logic                  ack,
    output logic [CNT_W-1:0]      pkt_toa,
    output logic [NPIX-1:0]       pkt_hitmap,
    output logic [NPIX*TOT_W-1:0] pkt_tot
);
    ev_state_e        st_q;
    logic [NPIX-1:0]  acc_edge;
    logic             any_edge;
    logic [NPIX-1:0]  map_q;
    logic [CNT_W-1:0] toa_q;
    logic             fire;
    logic             open_evt;
    logic             ev_open;
    logic [NPIX-1:0]  map_set;
    logic             strobe_q;

    prw_edge_qual #(.NPIX(NPIX)) i_qual (
        .redge    (pix_redge),
        .idle     (pix_idle),
        .accepted (acc_edge),
        .any_edge (any_edge)
    );

    assign ev_open  = (st_q == EV_OPEN);
    assign fire     = ev_open && none_pending(64'(map_q), 64'(pix_ready));
    assign open_evt = !ev_open && any_edge;
    assign map_set  = fire ? '0 : acc_edge;

    prw_toa_reg #(.CNT_W(CNT_W)) i_toa (
        .clk   (clk),
        .rst   (rst),
        .load  (open_evt),
        .count (bx_count),
        .toa   (toa_q)
    );

    prw_hitmap #(.NPIX(NPIX)) i_map (
        .clk      (clk),
        .rst      (rst),
        .clear    (fire),
        .set_bits (map_set),
        .map      (map_q)
    );

    prw_packer #(.NPIX(NPIX), .CNT_W(CNT_W)) i_pack (
        .clk        (clk),
        .rst        (rst),
        .fire       (fire),
        .toa        (toa_q),
        .map        (map_q),
        .tot        (pix_tot),
        .pkt_toa    (pkt_toa),
        .pkt_hitmap (pkt_hitmap),
        .pkt_tot    (pkt_tot)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= EV_IDLE;
            strobe_q <= 1'b0;
        end else begin
            strobe_q <= fire;
            if (fire)          st_q <= EV_IDLE;
            else if (open_evt) st_q <= EV_OPEN;
        end
    end

    assign redge_or = any_edge;
    assign wr_en    = strobe_q;
    assign ack      = strobe_q;
endmodule

// File: rtl/prw_write_logic_chk.sv
module prw_write_logic_chk #(
    parameter int NPIX  = 4,
    parameter int CNT_W = 8
) (
    input logic                clk,
    input logic                rst,
    input logic                wr_en,
    input logic                ack,
    input logic                ev_open,
    input logic [CNT_W-1:0]    toa_q,
    input logic [CNT_W-1:0]    pkt_toa,
    input logic [NPIX-1:0]     pkt_hitmap,
    input logic [NPIX*4-1:0]   pkt_tot
);
    logic [NPIX*4-1:0] nonhit_mask;

    always_comb begin
        for (int i = 0; i < NPIX; i++) begin
            nonhit_mask[i*4 +: 4] = pkt_hitmap[i] ? 4'h0 : 4'hF;
        end
    end

    assert_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !wr_en);

    assert_ack_with_write_R5: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> ack);

    assert_closed_after_write_R5: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> !ev_open);

    assert_map_nonzero_R4: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (pkt_hitmap != '0));

    assert_nonhit_zero_R7: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> ((pkt_tot & nonhit_mask) == '0));

    assert_hold_R11: assert property (@(posedge clk) disable iff (rst)
        !wr_en |-> ($stable(pkt_toa) && $stable(pkt_hitmap) && $stable(pkt_tot)));

    assert_toa_stable_R3: assert property (@(posedge clk) disable iff (rst)
        (ev_open && $past(ev_open)) |-> $stable(toa_q));
endmodule

bind prw_write_logic prw_write_logic_chk #(.NPIX(NPIX), .CNT_W(CNT_W)) i_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .ack        (ack),
    .ev_open    (ev_open),
    .toa_q      (toa_q),
    .pkt_toa    (pkt_toa),
    .pkt_hitmap (pkt_hitmap),
    .pkt_tot    (pkt_tot)
);

// File: tb/test_prw_write_logic.sv
`timescale 1ns/1ps
module test_prw_write_logic;
    localparam int NP = 4;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NP-1:0] pix_redge = '0;
    logic [NP-1:0] pix_idle  = '1;
    logic [NP-1:0] pix_ready = '0;
    logic [NP*4-1:0] pix_tot = '0;
    logic [CW-1:0] bx_count  = '0;
    logic          redge_or, wr_en, ack;
    logic [CW-1:0] pkt_toa;
    logic [NP-1:0] pkt_hitmap;
    logic [NP*4-1:0] pkt_tot;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    prw_write_logic #(.ROWS(2), .COLS(2), .CNT_W(CW)) i_prw_write_logic (
        .clk(clk), .rst(rst), .pix_redge(pix_redge), .pix_idle(pix_idle),
        .pix_ready(pix_ready), .pix_tot(pix_tot), .bx_count(bx_count),
        .redge_or(redge_or), .wr_en(wr_en), .ack(ack), .pkt_toa(pkt_toa),
        .pkt_hitmap(pkt_hitmap), .pkt_tot(pkt_tot)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] tv(input int p, input int i);
        return 4'((p * 5 + i * 3 + 1) & 15);
    endfunction

    function automatic logic [NP*4-1:0] exp_tot(input int p);
        logic [NP*4-1:0] r;
        r = '0;
        for (int i = 0; i < NP; i++) if (p[i]) r[i*4 +: 4] = tv(p, i);
        return r;
    endfunction

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 wr_en", 64'(wr_en), 0);
        chk("R1 ack", 64'(ack), 0);
        chk("R1 toa", 64'(pkt_toa), 0);
        chk("R1 map", 64'(pkt_hitmap), 0);
        chk("R1 tot", 64'(pkt_tot), 0);

        // Sweep of all hit patterns of the 2x2 region
        for (int p = 1; p < 16; p++) begin
            bx_count  = CW'(16 + p * 7);
            pix_redge = NP'(p);
            pix_idle  = '1;
            pix_ready = ~NP'(p);   // non-hit pixels ready: R8
            for (int i = 0; i < NP; i++) pix_tot[i*4 +: 4] = tv(p, i);
            #1 chk("R2 redge_or", 64'(redge_or), 1);
            @(negedge clk);
            pix_redge = '0;
            pix_idle  = ~NP'(p);
            bx_count  = bx_count + 1;
            for (int i = 0; i < NP; i++) begin
                if (p[i]) begin
                    chk("R8 no early write", 64'(wr_en), 0);
                    pix_ready[i] = 1'b1;
                    @(negedge clk);
                end
            end
            chk("R5 wr_en", 64'(wr_en), 1);
            chk("R5 ack", 64'(ack), 1);
            chk("R3 toa", 64'(pkt_toa), 64'(CW'(16 + p * 7)));
            chk("R4 map", 64'(pkt_hitmap), 64'(p));
            chk("R6 R7 tot", 64'(pkt_tot), 64'(exp_tot(p)));
            pix_ready = '0;
            pix_idle  = '1;
            @(negedge clk);
            chk("R5 pulse", 64'(wr_en), 0);
            chk("R11 hold", 64'(pkt_hitmap), 64'(p));
        end

        // R3 / R12: staggered edges, and an edge from a busy pixel
        pix_tot   = 16'h4321;
        bx_count  = 8'h40;
        pix_redge = 4'b0001; pix_idle = 4'b1111;
        @(negedge clk);
        bx_count  = 8'h41;
        pix_redge = 4'b0110; pix_idle = 4'b1010;
        #1 chk("R2 later edge", 64'(redge_or), 1);
        @(negedge clk);
        bx_count  = 8'h42;
        pix_redge = 4'b0100; pix_idle = 4'b1000;
        #1 chk("R12 busy edge no or", 64'(redge_or), 0);
        @(negedge clk);
        pix_redge = '0; pix_ready = 4'b0011;
        @(negedge clk);
        chk("R5 staggered write", 64'(wr_en), 1);
        chk("R3 first toa kept", 64'(pkt_toa), 64'h40);
        chk("R12 map", 64'(pkt_hitmap), 64'b0011);
        chk("R7 tot", 64'(pkt_tot), 64'h0021);

        // R9: new edge during the ack cycle
        bx_count  = 8'h55;
        pix_redge = 4'b1000; pix_idle = 4'b1111; pix_ready = '0;
        @(negedge clk);
        // R10: edge arriving in the write-condition cycle
        bx_count  = 8'h66;
        pix_redge = 4'b0100; pix_idle = 4'b0111; pix_ready = 4'b1000;
        @(negedge clk);
        chk("R9 write", 64'(wr_en), 1);
        chk("R9 new toa", 64'(pkt_toa), 64'h55);
        chk("R10 map", 64'(pkt_hitmap), 64'b1000);
        pix_redge = '0; pix_ready = 4'b1111; pix_idle = 4'b1111;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("R10 no event", 64'(wr_en), 0);
            chk("R11 hold toa", 64'(pkt_toa), 64'h55);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule